// File: doc/BRIEF.md
# Packet Length Gate and Block Segmenter

This block sits in front of a compression engine on an 8-bit byte stream with valid/ready handshakes and a last-byte marker. It withholds the opening bytes of each packet until the packet has proved it is at least `MIN_LEN` bytes long (32 by default). A packet that ends before that point is thrown away without a single byte or flag reaching the output. A packet that qualifies is passed on byte for byte, in order, as one unit.

While forwarding, the block cuts the packet into compression blocks of `BLK_LEN` bytes (16384 by default). Three sideband flags travel with each output byte: one on the first byte of a block, one on the last byte of a block, and one on the final byte of the packet. The final block of a packet carries whatever is left over after the full-size blocks.

The holding store is a small ring whose entries stay invisible to the reader until the packet qualifies. If the consumer never applies backpressure, the input accepts one byte on every clock.

Top module: `pkt_len_gate`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and directly after it rises, `out_valid` is 0, `in_ready` is 1, and any bytes held from an unfinished packet are lost.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and all three output flags keep their values into the next cycle.
- R3: A packet whose last byte (the byte accepted with `in_last`=1) arrives before its 32nd byte produces no output at all, and the byte accepted after it starts a new packet.
- R4: A packet of 32 or more bytes comes out complete and in input order, with `out_pkt_last` set on its final byte and on no other byte.
- R5: Counting bytes of a packet from index 0, `out_blk_first` is 1 exactly on indices that are multiples of 16384. `out_blk_last` is 1 exactly on indices whose remainder modulo 16384 is 16383 and on the packet's final byte. A byte with `out_pkt_last` therefore always has `out_blk_last`.
- R6: In every cycle where `out_ready` is 1, `in_ready` is 1, so a consumer that never stalls sees one byte per clock accepted.
- R7: No byte of a packet is offered before that packet's 32nd byte has been accepted. The first byte is offered in the cycle after the edge that accepts the 32nd byte.
- R8: The store never holds more than 32 bytes. With `out_ready` held at 0, a long packet is accepted for exactly 32 bytes before `in_ready` falls.
- R9: At the boundary, a 31-byte packet is dropped and a 32-byte packet is forwarded whole, as one block with both block flags set as R5 gives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take the input byte this cycle |
| in_data | input | DW | Input byte |
| in_last | input | 1 | Input byte is the final byte of its packet |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the output byte this cycle |
| out_data | output | DW | Output byte |
| out_blk_first | output | 1 | Byte opens a compression block |
| out_blk_last | output | 1 | Byte closes a compression block |
| out_pkt_last | output | 1 | Byte is the final byte of the packet |

## Verification
The bench aims at the length boundary: a 31-byte packet must vanish and a 32-byte one must pass. A design with an off-by-one threshold would leak or lose one of them. Short packets are placed directly ahead of long ones with no idle cycle between them, because a design that forgot to roll back the store or to restart its position count would emit stale bytes or set the block-first flag on the wrong byte. Long packets of exactly one block and of just over two blocks test the block flags, where a wrong modulus shows up as a misplaced first or last flag. Held output under backpressure, the 32-byte fill limit, the exact cycle of the first output, and a reset in the middle of a packet are also probed. A wrong ready path would stall a consumer that never stalls, or would overrun the ring.

// File: rtl/plg_pkg.sv
package plg_pkg;

  // Sideband carried with every stored byte.
  typedef struct packed {
    logic blk_first;
    logic blk_last;
    logic pkt_last;
  } plg_tag_t;

  // Position of the next byte inside its block.
  function automatic int unsigned pos_step(int unsigned pos, logic last, int unsigned blk);
    if (last || pos == blk - 1) return 0;
    return pos + 1;
  endfunction

  // True when the byte at this position ends a block.
  function automatic logic closes_block(int unsigned pos, logic last, int unsigned blk);
    return last || (pos == blk - 1);
  endfunction

  // True when the byte at this position is the one that qualifies the packet.
  function automatic logic reaches_min(int unsigned pos, int unsigned minl);
    return pos == minl - 1;
  endfunction

endpackage

// File: rtl/plg_tracker.sv
module plg_tracker #(
  parameter int MIN_LEN = 32,
  parameter int BLK_LEN = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             last,
  output plg_pkg::plg_tag_t tag,
  output logic             commit,
  output logic             drop
);
  import plg_pkg::*;

  localparam int PW = $clog2(BLK_LEN);

  logic [PW-1:0] pos;
  logic          qual;
  int unsigned   pos_u;

  assign pos_u  = 32'(pos);
  assign commit = qual || reaches_min(pos_u, MIN_LEN);
  assign drop   = !commit && last;

  always_comb begin
    tag.blk_first = (pos == '0);
    tag.blk_last  = closes_block(pos_u, last, BLK_LEN);
    tag.pkt_last  = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      qual <= 1'b0;
    end else if (take) begin
      pos  <= PW'(pos_step(pos_u, last, BLK_LEN));
      qual <= commit && !last;
    end
  end

endmodule

// File: rtl/plg_buffer.sv
module plg_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DW-1:0]     push_data,
  input  plg_pkg::plg_tag_t push_tag,
  input  logic              keep,
  input  logic              undo,
  input  logic              pop,
  output logic [DW-1:0]     head_data,
  output plg_pkg::plg_tag_t head_tag,
  output logic [LW-1:0]     fill,
  output logic [LW-1:0]     held
);
  import plg_pkg::*;

  logic [DW-1:0] dmem [DEPTH];
  plg_tag_t      tmem [DEPTH];
  logic [AW:0]   wr, rd, ck;

  assign fill      = wr - rd;
  assign held      = ck - rd;
  assign head_data = dmem[rd[AW-1:0]];
  assign head_tag  = tmem[rd[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !undo) begin
      dmem[wr[AW-1:0]] <= push_data;
      tmem[wr[AW-1:0]] <= push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr <= '0;
      rd <= '0;
      ck <= '0;
    end else begin
      if (push) begin
        if (keep) begin
          wr <= wr + 1'b1;
          ck <= wr + 1'b1;
        end else if (undo) begin
          wr <= ck;
        end else begin
          wr <= wr + 1'b1;
        end
      end
      if (pop) rd <= rd + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_len_gate.sv
module pkt_len_gate #(
  parameter int DW      = 8,
  parameter int MIN_LEN = 32,
  parameter int BLK_LEN = 16384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_blk_first,
  output logic          out_blk_last,
  output logic          out_pkt_last
);
  import plg_pkg::*;

  localparam int DEPTH = 1 << $clog2(MIN_LEN);
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = AW + 1;

  // Named internal events, also observed by the checker.
  logic          ev_take, ev_pop, ev_commit, ev_drop;
  logic [LW-1:0] fill_level, held_level;
  logic          buf_full, trk_commit, trk_drop;
  plg_tag_t      trk_tag, head_tag;

  assign buf_full  = (fill_level == LW'(DEPTH));
  assign out_valid = (held_level != '0);
  assign ev_pop    = out_valid && out_ready;
  assign in_ready  = !buf_full || ev_pop;
  assign ev_take   = in_valid && in_ready;
  assign ev_commit = ev_take && trk_commit;
  assign ev_drop   = ev_take && trk_drop;

  plg_tracker #(.MIN_LEN(MIN_LEN), .BLK_LEN(BLK_LEN)) u_tracker (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (ev_take),
    .last   (in_last),
    .tag    (trk_tag),
    .commit (trk_commit),
    .drop   (trk_drop)
  );

  plg_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_take),
    .push_data (in_data),
    .push_tag  (trk_tag),
    .keep      (trk_commit),
    .undo      (trk_drop),
    .pop       (ev_pop),
    .head_data (out_data),
    .head_tag  (head_tag),
    .fill      (fill_level),
    .held      (held_level)
  );

  assign out_blk_first = head_tag.blk_first;
  assign out_blk_last  = head_tag.blk_last;
  assign out_pkt_last  = head_tag.pkt_last;

endmodule

// File: rtl/plg_checker.sv
module plg_checker #(
  parameter int DW    = 8,
  parameter int LW    = 6,
  parameter int DEPTH = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_blk_first,
  input logic          out_blk_last,
  input logic          out_pkt_last,
  input logic          ev_commit,
  input logic          ev_drop,
  input logic          ev_pop,
  input logic [LW-1:0] fill_level,
  input logic [LW-1:0] held_level
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_blk_first)
                                   && $stable(out_blk_last) && $stable(out_pkt_last)));

  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (fill_level == $past(held_level) - LW'($past(ev_pop))));

  p_last_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pkt_last) |-> out_blk_last);

  p_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_no_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(ev_commit));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level <= LW'(DEPTH)) && (held_level <= fill_level));

endmodule

bind pkt_len_gate plg_checker #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) u_plg_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_blk_first (out_blk_first),
  .out_blk_last  (out_blk_last),
  .out_pkt_last  (out_pkt_last),
  .ev_commit     (ev_commit),
  .ev_drop       (ev_drop),
  .ev_pop        (ev_pop),
  .fill_level    (fill_level),
  .held_level    (held_level)
);

// File: tb/test_pkt_len_gate.sv
module test_pkt_len_gate;
  localparam int PER   = 10;
  localparam int MINL  = 32;
  localparam int BLK   = 16384;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_blk_first, out_blk_last, out_pkt_last;

  int total = 0;
  int bad = 0;
  int rdy_pct = 100;
  int stall_cnt = 0;
  logic [10:0] exp_q[$];

  always #(PER/2) clk = ~clk;

  pkt_len_gate i_pkt_len_gate (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_blk_first(out_blk_first), .out_blk_last(out_blk_last), .out_pkt_last(out_pkt_last)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected output of one packet, computed from the requirements.
  task automatic expect_pkt(input logic [7:0] bytes[]);
    int len = bytes.size();
    if (len < MINL) return;
    for (int i = 0; i < len; i++) begin
      logic f, be, pe;
      f  = (i % BLK) == 0;
      be = ((i % BLK) == BLK - 1) || (i == len - 1);
      pe = (i == len - 1);
      exp_q.push_back({pe, be, f, bytes[i]});
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    #(PER/4);
    while (!in_ready) begin
      stall_cnt++;
      @(negedge clk);
      #(PER/4);
    end
    @(posedge clk);
  endtask

  task automatic send_pkt(input int len, input int mode, input int gap_pct, input bit idle_after);
    logic [7:0] bytes[];
    bytes = new[len];
    for (int i = 0; i < len; i++) begin
      case (mode)
        0: bytes[i] = 8'($urandom);
        1: bytes[i] = 8'(i);
        default: bytes[i] = 8'hA5 ^ 8'(i / 7);
      endcase
    end
    expect_pkt(bytes);
    for (int i = 0; i < len; i++) begin
      if (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) begin
        @(negedge clk); in_valid = 1'b0;
      end
      put_byte(bytes[i], i == len - 1);
    end
    if (idle_after) begin
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Output side: drive ready, compare handshakes, check held values.
  initial begin
    logic       hold_pend = 1'b0;
    logic [10:0] snap = '0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) < rdy_pct);
      #(PER/4);
      if (hold_pend && out_valid)
        chk({out_pkt_last, out_blk_last, out_blk_first, out_data} == snap, "R2", "held output",
            int'({out_pkt_last, out_blk_last, out_blk_first, out_data}), int'(snap));
      hold_pend = out_valid && !out_ready;
      snap = {out_pkt_last, out_blk_last, out_blk_first, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected output byte", int'(out_data), -1);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R4", "data", int'(out_data), int'(e[7:0]));
          chk(out_blk_first == e[8], "R5", "block first flag", int'(out_blk_first), int'(e[8]));
          chk(out_blk_last == e[9], "R5", "block last flag", int'(out_blk_last), int'(e[9]));
          chk(out_pkt_last == e[10], "R4", "packet last flag", int'(out_pkt_last), int'(e[10]));
        end
      end
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", LIMIT, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #(PER/4);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    #(PER/4);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R7: first output only after the 32nd byte.
    rdy_pct = 100;
    begin
      logic [7:0] b[];
      b = new[48];
      for (int i = 0; i < 48; i++) b[i] = 8'(8'h40 + i);
      expect_pkt(b);
      for (int i = 0; i < 31; i++) put_byte(b[i], 1'b0);
      @(negedge clk); in_valid = 1'b0;
      #(PER/4);
      chk(out_valid == 1'b0, "R7", "valid before 32nd byte", int'(out_valid), 0);
      put_byte(b[31], 1'b0);
      @(negedge clk); in_valid = 1'b0;
      #(PER/4);
      chk(out_valid == 1'b1, "R7", "valid after 32nd byte", int'(out_valid), 1);
      for (int i = 32; i < 48; i++) put_byte(b[i], i == 47);
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    end
    wait_drain();

    // R9 boundary lengths, R3 drops.
    send_pkt(31, 1, 0, 1'b1);
    send_pkt(32, 0, 0, 1'b1);
    send_pkt(1, 0, 0, 1'b1);
    send_pkt(33, 2, 0, 1'b1);
    wait_drain();
    #(PER/4);
    chk(out_valid == 1'b0, "R9", "idle after boundary packets", int'(out_valid), 0);

    // R3: short packet followed at once by a long one.
    send_pkt(10, 0, 0, 1'b0);
    send_pkt(40, 1, 0, 1'b1);
    send_pkt(31, 0, 0, 1'b0);
    send_pkt(35, 0, 0, 1'b1);
    wait_drain();
    #(PER/4);
    chk(out_valid == 1'b0, "R3", "no output from short packets", int'(out_valid), 0);

    // R8: fill limit under full backpressure, then R1 asynchronous reset.
    rdy_pct = 0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i); in_last = 1'b0;
      #(PER/4);
      if (!in_ready) break;
      n++;
      @(posedge clk);
    end
    chk(n == 32, "R8", "bytes accepted before stall", n, 32);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #(PER/8);
    chk(out_valid == 1'b0, "R1", "out_valid on async reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready on async reset", int'(in_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rdy_pct = 100;
    send_pkt(33, 1, 0, 1'b1);
    wait_drain();

    // Random mix with backpressure and input gaps.
    rdy_pct = 60;
    for (int p = 0; p < 40; p++) begin
      int len;
      len = (p % 5 == 0) ? $urandom_range(20, 40) : $urandom_range(1, 220);
      send_pkt(len, p % 3, 20, (p % 4) != 0);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    wait_drain();

    // R5 and R6: block splitting with a consumer that never stalls.
    rdy_pct = 100;
    stall_cnt = 0;
    send_pkt(BLK, 1, 0, 1'b0);
    send_pkt(2 * BLK + 50, 0, 0, 1'b1);
    chk(stall_cnt == 0, "R6", "input stalls with ready consumer", stall_cnt, 0);
    wait_drain();
    chk(exp_q.size() == 0, "R4", "bytes still expected", exp_q.size(), 0);
    #(PER/4);
    chk(out_valid == 1'b0, "R4", "idle at end", int'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule